// File: doc/BRIEF.md
# Interrupt Trigger Notification Generator

This block turns interrupt level changes into notification writes. Each change arrives as an event that carries a source number and a level. Every source has one bit in a level register, and the bit follows the level reported for that source. A rising level queues a trigger for the source. A queued trigger leaves as one 64-bit write on a request/acknowledge bus. The write address comes from a notification-port register. The write data combines a trigger flag, an offset taken from the upper half of an offset register, and the source number. The data word is presented big-endian: its most significant byte belongs at the lowest byte address.

Software works through a small register port with combinational reads. A control register carries two bits. One selects level-signalled mode, which shuts the trigger path down. The other, when written as one, clears the state of every source. Three sticky error bits record a rejected source number, an event that arrived while the path was shut down, and an error in a write response. Queued triggers are served lowest source number first, with at most one write outstanding at a time.

Top module: `trigNotifyGen`

## Requirements
- R1: After reset, `reqValid` is 0, and the control, port, offset, level and error registers all read zero.
- R2: Register bits are numbered MSB-first: bit k sits at vector position 63-k. An accepted event for source n sets level-register bit n (vector position 63-n) when its level is 1, and clears that bit when its level is 0.
- R3: A request carries `reqAddr` equal to the port register with position 0 cleared, and `reqData` equal to TRIG_FLAG OR (offset register >> 32) OR n. Address and data stay stable, and `reqValid` stays high, until a cycle in which `reqAck` is high.
- R4: Position 0 of the port register is the valid bit. If a queued trigger is selected while that bit is clear, the trigger is discarded and no request is made, including after the bit is later set.
- R5: Queued triggers are issued lowest source number first. An event accepted at one edge raises `reqValid` after the next edge if the bus is idle. After the edge that samples `reqAck`, `reqValid` is low for at least one cycle.
- R6: A rising event for a source that already has a trigger queued is merged with it, so only one request is made.
- R7: While control bit 0 (vector position 63) is set, events are ignored: the level register and the queue are unchanged. Each ignored in-range event sets error bit 1. Queued triggers are held, not issued, until the bit is cleared. A request already in flight completes normally.
- R8: A control-register write with bit 1 (vector position 62) set clears the level register and every queued trigger in the same edge. The written value is stored unchanged.
- R9: An event whose source number is NUM_SRC or higher is rejected. It changes no state except error bit 2.
- R10: A cycle in which `reqAck` and `rspErr` are both high while a request is outstanding sets error bit 0. Writing a 1 to an error bit clears it.
- R11: The registers sit at these addresses: 0 control, 1 port, 2 offset, 3 level (read-only; writes are ignored), 4 errors in positions 2:0. Every other address reads all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for reads and writes |
| regWdata | input | 64 | Register write data |
| regRdata | output | 64 | Combinational read data for `regAddr` |
| evtValid | input | 1 | Level-change event strobe |
| evtSrc | input | 5 | Source number of the event |
| evtLevel | input | 1 | New level of the source |
| reqValid | output | 1 | Notification write request pending |
| reqAddr | output | 64 | Notification target address |
| reqData | output | 64 | Trigger word, big-endian |
| reqAck | input | 1 | Request accepted this cycle |
| rspErr | input | 1 | Response error, valid with `reqAck` |

## Verification
The first pattern is a lone rising and falling event on an idle bus, which checks the level-bit position and the exact trigger word. The second holds back the acknowledge while several sources, one of them raised twice, fill the queue. This separates lowest-first ordering and merging from arrival order. The port valid bit, the mode bit and the source-clear bit are each toggled while triggers are queued or in flight. These runs show the difference between dropping, holding and flushing a trigger. Out-of-range source numbers and erroring responses exercise each sticky error bit separately, and a cycle-accurate model compares the request outputs on every clock.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int SRC_W = 5;
  localparam int REG_AW = 3;
  localparam int ERR_W = 3;

  localparam logic [REG_AW-1:0] REG_CTRL  = 3'd0;
  localparam logic [REG_AW-1:0] REG_PORT  = 3'd1;
  localparam logic [REG_AW-1:0] REG_OFFS  = 3'd2;
  localparam logic [REG_AW-1:0] REG_LEVEL = 3'd3;
  localparam logic [REG_AW-1:0] REG_ERR   = 3'd4;

  // MSB-first numbering: control bit 0 is vector position 63.
  localparam int CTRL_MODE_POS  = 63;
  localparam int CTRL_RESET_POS = 62;

  typedef struct packed {
    logic             load;
    logic [SRC_W-1:0] src;
    logic             done;
    logic             busErr;
    logic             modeErr;
    logic             rangeErr;
    logic             lvlWe;
    logic             lvlVal;
    logic [SRC_W-1:0] lvlSrc;
  } trigStrobe_t;
endpackage

// File: rtl/trigCtrl.sv
module trigCtrl
  import trig_pkg::*;
#(
  parameter int NUM_SRC = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evtValid,
  input  logic [SRC_W-1:0] evtSrc,
  input  logic             evtLevel,
  input  logic             modeLevel,
  input  logic             srcReset,
  input  logic             portValid,
  input  logic             reqAck,
  input  logic             rspErr,
  output trigStrobe_t      strobe,
  output logic             reqValid
);
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] clrMask;
  logic [NUM_SRC-1:0] setMask;
  logic [SRC_W-1:0]   selIdx;
  logic               busy;
  logic               inRange;
  logic               evtOk;
  logic               issueGo;

  // lowest pending source wins
  always_comb begin
    selIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend[i]) selIdx = SRC_W'(i);
    end
  end

  assign inRange = {1'b0, evtSrc} < (SRC_W + 1)'(NUM_SRC);
  assign evtOk   = evtValid && inRange && !modeLevel;
  assign issueGo = !busy && !modeLevel && (|pend);
  assign clrMask = issueGo ? (NUM_SRC'(1) << selIdx) : '0;
  assign setMask = (evtOk && evtLevel) ? (NUM_SRC'(1) << evtSrc) : '0;

  always_comb begin
    strobe          = '0;
    strobe.load     = issueGo && portValid;
    strobe.src      = selIdx;
    strobe.done     = busy && reqAck;
    strobe.busErr   = busy && reqAck && rspErr;
    strobe.modeErr  = evtValid && inRange && modeLevel;
    strobe.rangeErr = evtValid && !inRange;
    strobe.lvlWe    = evtOk;
    strobe.lvlVal   = evtLevel;
    strobe.lvlSrc   = evtSrc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend <= '0;
      busy <= 1'b0;
    end else begin
      pend <= srcReset ? '0 : ((pend & ~clrMask) | setMask);
      if (strobe.load)      busy <= 1'b1;
      else if (strobe.done) busy <= 1'b0;
    end
  end

  assign reqValid = busy;
endmodule

// File: rtl/trigData.sv
module trigData
  import trig_pkg::*;
#(
  parameter int          NUM_SRC   = 20,
  parameter logic [63:0] TRIG_FLAG = 64'h8000_0000_0000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [63:0]       regWdata,
  output logic [63:0]       regRdata,
  input  trigStrobe_t       strobe,
  output logic [63:0]       reqAddr,
  output logic [63:0]       reqData,
  output logic              modeLevel,
  output logic              srcReset,
  output logic              portValid,
  output logic [NUM_SRC-1:0] levelVec
);
  logic [63:0]      ctrlReg;
  logic [63:0]      portReg;
  logic [63:0]      offsReg;
  logic [ERR_W-1:0] errReg;
  logic [ERR_W-1:0] errClr;
  logic [63:0]      levelWord;
  logic [NUM_SRC-1:0] lvlHot;

  assign modeLevel = ctrlReg[CTRL_MODE_POS];
  assign portValid = portReg[0];
  assign srcReset  = regWe && (regAddr == REG_CTRL) && regWdata[CTRL_RESET_POS];
  assign errClr    = (regWe && (regAddr == REG_ERR)) ? regWdata[ERR_W-1:0] : '0;
  assign lvlHot    = NUM_SRC'(1) << strobe.lvlSrc;

  // source n shows at MSB-first bit n
  always_comb begin
    levelWord = '0;
    for (int n = 0; n < NUM_SRC; n++) levelWord[63-n] = levelVec[n];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      portReg  <= '0;
      offsReg  <= '0;
      errReg   <= '0;
      levelVec <= '0;
      reqAddr  <= '0;
      reqData  <= '0;
    end else begin
      if (regWe) begin
        case (regAddr)
          REG_CTRL: ctrlReg <= regWdata;
          REG_PORT: portReg <= regWdata;
          REG_OFFS: offsReg <= regWdata;
          default: ;
        endcase
      end
      errReg <= (errReg & ~errClr) | {strobe.rangeErr, strobe.modeErr, strobe.busErr};
      if (srcReset)
        levelVec <= '0;
      else if (strobe.lvlWe)
        levelVec <= strobe.lvlVal ? (levelVec | lvlHot) : (levelVec & ~lvlHot);
      if (strobe.load) begin
        reqAddr <= {portReg[63:1], 1'b0};
        reqData <= TRIG_FLAG | {32'h0, offsReg[63:32]} | 64'(strobe.src);
      end
    end
  end

  always_comb begin
    case (regAddr)
      REG_CTRL:  regRdata = ctrlReg;
      REG_PORT:  regRdata = portReg;
      REG_OFFS:  regRdata = offsReg;
      REG_LEVEL: regRdata = levelWord;
      REG_ERR:   regRdata = 64'(errReg);
      default:   regRdata = '1;
    endcase
  end
endmodule

// File: rtl/trigNotifyGen.sv
module trigNotifyGen
  import trig_pkg::*;
#(
  parameter int          NUM_SRC   = 20,
  parameter logic [63:0] TRIG_FLAG = 64'h8000_0000_0000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [63:0]       regWdata,
  output logic [63:0]       regRdata,
  input  logic              evtValid,
  input  logic [SRC_W-1:0]  evtSrc,
  input  logic              evtLevel,
  output logic              reqValid,
  output logic [63:0]       reqAddr,
  output logic [63:0]       reqData,
  input  logic              reqAck,
  input  logic              rspErr
);
  trigStrobe_t        strobe;
  logic               modeLevel;
  logic               srcReset;
  logic               portValid;
  logic [NUM_SRC-1:0] levelVec;

  trigCtrl #(.NUM_SRC(NUM_SRC)) uCtrl (
    .clk(clk), .rstN(rstN),
    .evtValid(evtValid), .evtSrc(evtSrc), .evtLevel(evtLevel),
    .modeLevel(modeLevel), .srcReset(srcReset), .portValid(portValid),
    .reqAck(reqAck), .rspErr(rspErr),
    .strobe(strobe), .reqValid(reqValid)
  );

  trigData #(.NUM_SRC(NUM_SRC), .TRIG_FLAG(TRIG_FLAG)) uData (
    .clk(clk), .rstN(rstN),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .strobe(strobe), .reqAddr(reqAddr), .reqData(reqData),
    .modeLevel(modeLevel), .srcReset(srcReset), .portValid(portValid),
    .levelVec(levelVec)
  );
endmodule

// File: rtl/trigNotifyChk.sv
module trigNotifyChk #(
  parameter int NUM_SRC = 20
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic               reqAck,
  input logic [63:0]        reqAddr,
  input logic [63:0]        reqData,
  input logic               modeLevel,
  input logic               portValid,
  input logic               srcReset,
  input logic [NUM_SRC-1:0] levelVec
);
  // R3: request is held steady until accepted
  a_r3_hold_until_ack: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqAck |=> reqValid && $stable(reqAddr) && $stable(reqData));

  // R5: one outstanding request, idle cycle after acceptance
  a_r5_gap_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqAck |=> !reqValid);

  // R4: invalid port never launches a request
  a_r4_no_launch_invalid: assert property (@(posedge clk) disable iff (!rstN)
    !portValid |=> !$rose(reqValid));

  // R7: level-signalled mode never launches a request
  a_r7_mode_blocks: assert property (@(posedge clk) disable iff (!rstN)
    modeLevel |=> !$rose(reqValid));

  // R8: source clear empties the level register
  a_r8_level_cleared: assert property (@(posedge clk) disable iff (!rstN)
    srcReset |=> levelVec == '0);
endmodule

bind trigNotifyGen trigNotifyChk #(.NUM_SRC(NUM_SRC)) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAck(reqAck),
  .reqAddr(reqAddr), .reqData(reqData), .modeLevel(modeLevel),
  .portValid(portValid), .srcReset(srcReset), .levelVec(levelVec)
);

// File: tb/tb_trigNotifyGen.sv
`timescale 1ns/1ps
module tb_trigNotifyGen;
  localparam int N = 20;
  localparam logic [63:0] FLAG = 64'h8000_0000_0000_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [63:0] regWdata = '0;
  logic [63:0] regRdata;
  logic evtValid = 1'b0;
  logic [4:0] evtSrc = '0;
  logic evtLevel = 1'b0;
  logic reqValid;
  logic [63:0] reqAddr, reqData;
  logic reqAck = 1'b0;
  logic rspErr = 1'b0;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  // responder controls
  bit ackEnable = 1;
  bit errNext = 0;
  int ackWait = 1;
  int waitCnt = 0;
  int srcLog[$];
  logic [63:0] dataLog[$];
  logic [63:0] addrLog[$];

  // reference model state
  logic [63:0] mCtrl, mPort, mOff, mAddr, mData;
  logic [N-1:0] mLvl, mPend, nPend;
  logic mBusy;
  logic [2:0] mErr, eNew;
  int sel;

  always #2.5 clk = ~clk;

  trigNotifyGen dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .evtValid(evtValid),
    .evtSrc(evtSrc), .evtLevel(evtLevel), .reqValid(reqValid),
    .reqAddr(reqAddr), .reqData(reqData), .reqAck(reqAck), .rspErr(rspErr)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      mCtrl = '0; mPort = '0; mOff = '0; mAddr = '0; mData = '0;
      mLvl = '0; mPend = '0; mBusy = 0; mErr = '0;
    end else begin
      nPend = mPend;
      eNew = '0;
      if (mBusy) begin
        if (reqAck) begin
          mBusy = 0;
          if (rspErr) eNew[0] = 1;
        end
      end else if (!mCtrl[63] && mPend != 0) begin
        sel = 0;
        for (int i = N - 1; i >= 0; i--) if (mPend[i]) sel = i;
        nPend[sel] = 0;
        if (mPort[0]) begin
          mBusy = 1;
          mAddr = mPort & ~64'h1;
          mData = FLAG | (mOff >> 32) | 64'(sel);
        end
      end
      if (evtValid) begin
        if (int'(evtSrc) >= N) eNew[2] = 1;
        else if (mCtrl[63]) eNew[1] = 1;
        else begin
          mLvl[evtSrc] = evtLevel;
          if (evtLevel) nPend[evtSrc] = 1;
        end
      end
      if (regWe) begin
        case (regAddr)
          3'd0: begin
            if (regWdata[62]) begin nPend = '0; mLvl = '0; end
            mCtrl = regWdata;
          end
          3'd1: mPort = regWdata;
          3'd2: mOff = regWdata;
          3'd4: mErr = mErr & ~regWdata[2:0];
          default: ;
        endcase
      end
      mErr = mErr | eNew;
      mPend = nPend;
    end
  end

  // compare on every cycle; drive responder
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk(64'(reqValid), 64'(mBusy), "R5 reqValid vs model");
      if (mBusy) begin
        chk(reqAddr, mAddr, "R3 reqAddr vs model");
        chk(reqData, mData, "R3 reqData vs model");
      end
    end
    if (reqValid && !reqAck && ackEnable) begin
      if (waitCnt >= ackWait) begin
        reqAck = 1; rspErr = errNext; waitCnt = 0;
        srcLog.push_back(int'(reqData[4:0]));
        dataLog.push_back(reqData);
        addrLog.push_back(reqAddr);
      end else waitCnt++;
    end else begin
      reqAck = 0; rspErr = 0;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=<20000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk);
    regWe = 1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 0;
  endtask

  task automatic ev(input int s, input bit lv);
    @(negedge clk);
    evtValid = 1; evtSrc = 5'(s); evtLevel = lv;
    @(negedge clk);
    evtValid = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [63:0] exp, input string tag);
    @(negedge clk);
    regAddr = a;
    #1;
    chk(regRdata, exp, tag);
  endtask

  logic [63:0] port;
  int base;

  initial begin
    tick(3);
    rstN = 1;
    // R1 / R11 reset state and map
    chk(64'(reqValid), 0, "R1 reqValid after reset");
    rd(3'd0, 0, "R1 ctrl reset");
    rd(3'd1, 0, "R1 port reset");
    rd(3'd2, 0, "R1 offset reset");
    rd(3'd3, 0, "R1 level reset");
    rd(3'd4, 0, "R1 err reset");
    rd(3'd5, '1, "R11 unmapped reads ones");
    rd(3'd7, '1, "R11 unmapped reads ones");

    port = 64'h0000_00AB_CDE0_1001;
    wr(3'd1, port);
    wr(3'd2, 64'h0000_0040_0000_0000);
    rd(3'd1, port, "R11 port readback");
    wr(3'd3, 64'hFFFF);
    rd(3'd3, 0, "R11 level write ignored");

    // R2 / R3 single trigger
    ev(3, 1);
    rd(3'd3, 64'h1 << (63 - 3), "R2 level bit for source 3");
    tick(6);
    chk(64'(srcLog.size()), 1, "R3 one request");
    chk(dataLog[0], FLAG | 64'h40 | 64'd3, "R3 trigger word");
    chk(addrLog[0], port & ~64'h1, "R3 target address");
    ev(3, 0);
    rd(3'd3, 0, "R2 level cleared");
    tick(4);
    chk(64'(srcLog.size()), 1, "R2 falling edge no request");

    // R5 / R6 ordering and merge
    ackEnable = 0;
    ev(9, 1); ev(2, 1); ev(7, 1); ev(7, 1);
    tick(3);
    ackEnable = 1;
    tick(20);
    chk(64'(srcLog.size()), 4, "R6 merged count");
    chk(64'(srcLog[1]), 9, "R5 in-flight first");
    chk(64'(srcLog[2]), 2, "R5 lowest next");
    chk(64'(srcLog[3]), 7, "R5 then 7");

    // R4 invalid port drops trigger
    wr(3'd1, port & ~64'h1);
    ev(4, 1);
    tick(4);
    wr(3'd1, port);
    tick(6);
    chk(64'(srcLog.size()), 4, "R4 dropped trigger");

    // R8 clear flushes queue and level
    ackEnable = 0;
    ev(12, 1); ev(13, 1);
    wr(3'd0, 64'h4000_0000_0000_0000);
    rd(3'd0, 64'h4000_0000_0000_0000, "R8 ctrl stored as written");
    rd(3'd3, 0, "R8 level cleared");
    ackEnable = 1;
    tick(10);
    chk(64'(srcLog.size()), 5, "R8 only in-flight completes");
    chk(64'(srcLog[4]), 12, "R8 in-flight source");

    // R7 mode holds queue and ignores events
    ackEnable = 0;
    ev(10, 1); ev(11, 1);
    wr(3'd0, 64'h8000_0000_0000_0000);
    ackEnable = 1;
    ev(6, 1);
    tick(10);
    chk(64'(srcLog.size()), 6, "R7 in-flight completes, queue held");
    rd(3'd3, (64'h1 << 53) | (64'h1 << 52), "R7 level unchanged by ignored event");
    rd(3'd4, 64'h2, "R7 mode error bit");
    wr(3'd4, 64'h2);
    rd(3'd4, 0, "R10 error clear by write");
    wr(3'd0, 64'h0);
    tick(8);
    chk(64'(srcLog.size()), 7, "R7 held trigger released");
    chk(64'(srcLog[6]), 11, "R7 released source");

    // R9 out-of-range source
    ev(20, 1);
    ev(31, 1);
    rd(3'd4, 64'h4, "R9 range error bit");
    rd(3'd3, (64'h1 << 53) | (64'h1 << 52), "R9 level unchanged");
    tick(4);
    chk(64'(srcLog.size()), 7, "R9 no request");
    wr(3'd4, 64'h4);

    // R10 response error
    errNext = 1;
    ev(1, 1);
    tick(6);
    errNext = 0;
    rd(3'd4, 64'h1, "R10 bus error sticky");
    tick(3);
    rd(3'd4, 64'h1, "R10 bus error stays");
    wr(3'd4, 64'h1);
    rd(3'd4, 0, "R10 bus error cleared");

    tick(4);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule